// File: doc/BRIEF.md
# Guarded Single-Port Data Memory

This block is a word-addressed data store with one access port. In each cycle the port does either one read or one write. A read acts like combinational logic: data out follows the address in the same cycle. A write takes effect only at the rising clock edge.

The address input is wider than the storage needs. An address past the last implemented word does not wrap onto a lower word. Instead, a combinational error flag goes high and the access is blocked. A blocked write leaves every word unchanged, and a blocked read returns zero.

A range detector decodes the address against the depth. When the depth is a power of two, it tests the address bits above the index field for any one bit. For any other depth, it uses a magnitude compare. An operation decoder gives the write priority when both enables are raised. A flop array holds the words.

Top module: `dmem_guarded`

## Requirements
- R1: With rd_en high, wr_en low and an in-range address, rdata equals the word stored at that address in the same cycle, with no clock edge in between.
- R2: With wr_en high and an in-range address, wdata is stored at the rising clock edge. A read of that address after the edge returns it.
- R3: err is combinational and is 1 exactly when (rd_en or wr_en) is high and addr is greater than or equal to DEPTH.
- R4: With both enables low, err is 0 for every address, including out-of-range ones.
- R5: A write to an out-of-range address changes no stored word. This includes the word that a wrapped address would reach.
- R6: A read from an out-of-range address (rd_en high, wr_en low) drives rdata to 0.
- R7: When rd_en and wr_en are both high, the write is performed and the error rule of R3 still applies. rdata is not defined in that cycle.
- R8: With rd_en low, rdata is 0.
- R9: With wr_en low, a clock edge changes no stored word, whatever wdata and rd_en carry.
- R10: Address DEPTH-1 is in range and address DEPTH is out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to be written |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request; wins over rd_en |
| rdata | output | DATA_W | Word read; zero when not reading or blocked |
| err | output | 1 | Address out of range during an enabled access |

## Verification
The bench builds two copies with a 16-bit word and an 8-bit address. One copy has a depth of 16, a power of two, which selects the upper-bit range detector. The other has a depth of 12, which selects the magnitude compare.

Both copies see the same stimulus. Address 12 therefore exercises the range edge of the 12-deep copy while it is an ordinary word for the 16-deep copy. Address 16 and addresses such as 0x83 are out of range for both copies. These addresses would alias onto low words if the detector wrapped, which makes a missing block visible as a corrupted word.

// File: rtl/dmem_guarded_pkg.sv
package dmem_guarded_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dmem_range_det.sv
module dmem_range_det #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DEPTH  = 1024,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              out_of_range
);
   import dmem_guarded_pkg::*;

   localparam bit POW2 = is_pow2(DEPTH);

   generate
      if (POW2 && (ADDR_W > IDX_W)) begin : g_upper_bits
         assign out_of_range = |addr[ADDR_W-1:IDX_W];
      end else if (POW2) begin : g_full_cover
         assign out_of_range = 1'b0;
      end else begin : g_compare
         localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);
         assign out_of_range = (addr >= LIMIT);
      end
   endgenerate

endmodule

// File: rtl/dmem_op_decode.sv
module dmem_op_decode (
   input  logic                          rd_en,
   input  logic                          wr_en,
   input  logic                          out_of_range,
   output dmem_guarded_pkg::acc_kind_e   kind,
   output logic                          err
);
   import dmem_guarded_pkg::*;

   always_comb begin
      err  = (rd_en | wr_en) & out_of_range;
      kind = ACC_IDLE;
      if (!out_of_range) begin
         if (wr_en)      kind = ACC_WRITE;
         else if (rd_en) kind = ACC_READ;
      end
   end

endmodule

// File: rtl/dmem_word_store.sv
module dmem_word_store #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 1024,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rword
);
   logic [DATA_W-1:0] words [DEPTH];

   generate
      for (genvar w = 0; w < DEPTH; w++) begin : g_word
         always_ff @(posedge clk) begin
            if (we && (idx == IDX_W'(w))) words[w] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rword = '0;
      if (32'(idx) < DEPTH) rword = words[idx];
   end

endmodule

// File: rtl/dmem_guarded.sv
module dmem_guarded #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);
   import dmem_guarded_pkg::*;

   localparam int unsigned IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dmem_guarded: DEPTH must be at least 2");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("dmem_guarded: ADDR_W too narrow for DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("dmem_guarded: DATA_W must be positive");
      end
   endgenerate

   logic       oor;
   acc_kind_e  kind;
   logic [DATA_W-1:0] rword;

   dmem_range_det #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_range (
      .addr         (addr),
      .out_of_range (oor)
   );

   dmem_op_decode u_dec (
      .rd_en        (rd_en),
      .wr_en        (wr_en),
      .out_of_range (oor),
      .kind         (kind),
      .err          (err)
   );

   dmem_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (kind == ACC_WRITE),
      .idx   (addr[IDX_W-1:0]),
      .wdata (wdata),
      .rword (rword)
   );

   assign rdata = (kind == ACC_READ) ? rword : '0;

endmodule

// File: rtl/dmem_guarded_chk.sv
module dmem_guarded_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              rd_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] rdata,
   input logic              err
);
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   logic beyond;
   assign beyond = (33'(addr) >= 33'(DEPTH));

   p_idle_no_err_r4: assert property (@(posedge clk) disable iff (!armed)
      (!rd_en && !wr_en) |-> !err);

   p_err_when_beyond_r3: assert property (@(posedge clk) disable iff (!armed)
      ((rd_en || wr_en) && beyond) |-> err);

   p_no_err_in_range_r10: assert property (@(posedge clk) disable iff (!armed)
      (!beyond) |-> !err);

   p_blocked_read_zero_r6: assert property (@(posedge clk) disable iff (!armed)
      (rd_en && !wr_en && beyond) |-> (rdata == '0));

   p_no_read_zero_r8: assert property (@(posedge clk) disable iff (!armed)
      (!rd_en) |-> (rdata == '0));

   p_write_then_read_r2: assert property (@(posedge clk) disable iff (!armed)
      ($past(wr_en) && !$past(beyond) && rd_en && !wr_en && (addr == $past(addr)))
      |-> (rdata == $past(wdata)));

endmodule

bind dmem_guarded dmem_guarded_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .addr  (addr),
   .wdata (wdata),
   .rd_en (rd_en),
   .wr_en (wr_en),
   .rdata (rdata),
   .err   (err)
);

// File: tb/dmem_guarded_bench.sv
module dmem_guarded_bench;
   localparam int DW = 16;
   localparam int AW = 8;
   localparam int DA = 16;
   localparam int DB = 12;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [DW-1:0] rdata_a, rdata_b;
   logic err_a, err_b;

   dmem_guarded #(.DATA_W(DW), .DEPTH(DA), .ADDR_W(AW)) u_dmem_guarded (
      .clk(clk), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
      .rdata(rdata_a), .err(err_a));

   dmem_guarded #(.DATA_W(DW), .DEPTH(DB), .ADDR_W(AW)) u_dmem_guarded_b (
      .clk(clk), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
      .rdata(rdata_b), .err(err_b));

   logic [DW-1:0] shadow_a [DA];
   logic [DW-1:0] shadow_b [DB];
   bit known_a [DA];
   bit known_b [DB];

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic r, input logic w);
      @(negedge clk);
      addr = a; wdata = d; rd_en = r; wr_en = w;
      #1;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic r);
      drive(a, d, r, 1'b1);
      @(posedge clk);
      if (int'(a) < DA) begin shadow_a[a] = d; known_a[a] = 1; end
      if (int'(a) < DB) begin shadow_b[a] = d; known_b[a] = 1; end
   endtask

   task automatic check_all_words(input string req);
      for (int i = 0; i < DA; i++) begin
         drive(AW'(i), 16'hDEAD, 1'b1, 1'b0);
         if (known_a[i]) chk(req, rdata_a, shadow_a[i]);
         if (i < DB && known_b[i]) chk(req, rdata_b, shadow_b[i]);
      end
   endtask

   task automatic t_reset_state();
      drive(8'd200, 16'h1234, 1'b0, 1'b0);
      chk("R4 idle err a", {15'd0, err_a}, 16'd0);
      chk("R4 idle err b", {15'd0, err_b}, 16'd0);
      chk("R8 idle rdata a", rdata_a, 16'd0);
      chk("R8 idle rdata b", rdata_b, 16'd0);
   endtask

   task automatic t_fill_and_read();
      for (int i = 0; i < DA; i++) do_write(AW'(i), 16'hA500 ^ DW'(i * 16'h0111), 1'b0);
      check_all_words("R1 R2 readback");
      do_write(8'd5, 16'h0000, 1'b0);
      do_write(8'd6, 16'hFFFF, 1'b0);
      drive(8'd5, 16'h0, 1'b1, 1'b0);
      chk("R1 zero word a", rdata_a, 16'h0000);
      drive(8'd6, 16'h0, 1'b1, 1'b0);
      chk("R1 ones word b", rdata_b, 16'hFFFF);
   endtask

   task automatic t_comb_read();
      drive(8'd3, 16'h0, 1'b1, 1'b0);
      chk("R1 comb a3", rdata_a, shadow_a[3]);
      addr = 8'd9; #1;
      chk("R1 comb a9 same cycle", rdata_a, shadow_a[9]);
      chk("R1 comb b9 same cycle", rdata_b, shadow_b[9]);
   endtask

   task automatic t_write_disabled();
      drive(8'd2, 16'h7777, 1'b1, 1'b0);
      @(posedge clk);
      drive(8'd2, 16'h0, 1'b1, 1'b0);
      chk("R9 no write a", rdata_a, shadow_a[2]);
      chk("R9 no write b", rdata_b, shadow_b[2]);
   endtask

   task automatic t_boundary();
      drive(8'd11, 16'h0, 1'b1, 1'b0);
      chk("R10 b last word err", {15'd0, err_b}, 16'd0);
      chk("R10 b last word data", rdata_b, shadow_b[11]);
      drive(8'd12, 16'h0, 1'b1, 1'b0);
      chk("R10 b depth err", {15'd0, err_b}, 16'd1);
      chk("R3 a addr12 no err", {15'd0, err_a}, 16'd0);
      drive(8'd15, 16'h0, 1'b1, 1'b0);
      chk("R10 a last word err", {15'd0, err_a}, 16'd0);
      drive(8'd16, 16'h0, 1'b0, 1'b1);
      chk("R10 a depth err", {15'd0, err_a}, 16'd1);
      chk("R3 b write err", {15'd0, err_b}, 16'd1);
      drive(8'hFF, 16'h0, 1'b1, 1'b0);
      chk("R3 top addr err a", {15'd0, err_a}, 16'd1);
   endtask

   task automatic t_blocked_write();
      do_write(8'd12, 16'hBEEF, 1'b0);
      do_write(8'h83, 16'hC0DE, 1'b0);
      do_write(8'h90, 16'hF00D, 1'b0);
      do_write(8'd16, 16'h4242, 1'b0);
      check_all_words("R5 blocked write");
   endtask

   task automatic t_blocked_read();
      drive(8'h83, 16'h0, 1'b1, 1'b0);
      chk("R6 oob read a", rdata_a, 16'd0);
      chk("R6 oob read b", rdata_b, 16'd0);
      drive(8'd13, 16'h0, 1'b1, 1'b0);
      chk("R6 oob read b13", rdata_b, 16'd0);
      chk("R1 a13 in range", rdata_a, shadow_a[13]);
   endtask

   task automatic t_idle_oob();
      drive(8'd250, 16'h0, 1'b0, 1'b0);
      chk("R4 idle oob a", {15'd0, err_a}, 16'd0);
      chk("R4 idle oob b", {15'd0, err_b}, 16'd0);
      chk("R8 idle oob rdata", rdata_a, 16'd0);
   endtask

   task automatic t_both_enables();
      do_write(8'd4, 16'h5A5A, 1'b1);
      drive(8'd4, 16'h0, 1'b1, 1'b0);
      chk("R7 write wins a", rdata_a, 16'h5A5A);
      chk("R7 write wins b", rdata_b, 16'h5A5A);
      drive(8'd14, 16'h1111, 1'b1, 1'b1);
      chk("R7 both oob err b", {15'd0, err_b}, 16'd1);
      chk("R7 both in range err a", {15'd0, err_a}, 16'd0);
      @(posedge clk);
      shadow_a[14] = 16'h1111;
      drive(8'd14, 16'h0, 1'b1, 1'b0);
      chk("R7 write wins a14", rdata_a, 16'h1111);
   endtask

   initial begin
      for (int i = 0; i < DA; i++) known_a[i] = 0;
      for (int i = 0; i < DB; i++) known_b[i] = 0;
      t_reset_state();
      t_fill_and_read();
      t_comb_read();
      t_write_disabled();
      t_boundary();
      t_blocked_write();
      t_blocked_read();
      t_idle_oob();
      t_both_enables();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule